// File: doc/BRIEF.md
# General-Purpose Event and Slot Hot-Plug Status Unit

This unit keeps a 16-bit event status register and a 16-bit event enable register. Software reaches both one byte at a time. Status bits are cleared by writing ones, and each byte is cleared separately. The enable register is replaced one byte at a time. Next to these sit two 32-bit slot bitmaps, one recording inserted slots and one recording removed slots. Software can read and write both bitmaps as full words.

Hardware reports a slot event as a single-cycle strobe. The strobe carries a slot number and a flag that says whether the slot was inserted or removed. The event wipes both bitmaps, records the slot in the matching bitmap and raises the hot-plug bit (bit 1) of the status register. If enable bit 1 is set, the unit also pulses the system control interrupt for one clock.

Software requests a removal by writing a word to the eject register. The unit answers with a one-cycle strobe that carries the index of the lowest set bit of that word.

Top module: `gpe_hotplug_unit`

## Requirements
- R1: After reset, the status register, the enable register and both bitmaps read zero, and `sci_o` and `ej_valid_o` are low.
- R2: The byte read at `gpe_addr_i` is as follows: 0 gives status[7:0], 1 gives status[15:8], 2 gives enable[7:0] and 3 gives enable[15:8]. The read is combinational.
- R3: A byte write to address 0 or 1 clears the status bits where the written byte has ones. It changes nothing else in that byte and nothing in the other byte.
- R4: A byte write to address 2 or 3 replaces that byte of the enable register and leaves the other byte unchanged.
- R5: When `hp_sel_i` is 0, the inserted bitmap is selected; when it is 1, the removed bitmap is selected. A write replaces all 32 bits of the selected bitmap, and `hp_rdata_o` returns the selected bitmap.
- R6: An event sampled on a clock edge does three things at that edge. It zeroes both bitmaps. It then sets bit `ev_slot_i` of the inserted bitmap when `ev_insert_i` is 1, or of the removed bitmap when it is 0. It also sets status bit 1.
- R7: `sci_o` is high for exactly the one cycle after an event edge, and only if enable bit 1 was set at that edge. Otherwise `sci_o` stays low.
- R8: A nonzero eject write makes `ej_valid_o` high for the following cycle only, with `ej_slot_o` equal to the index of the lowest set bit of the written word. An eject write of zero produces no strobe.
- R9: `ej_rdata_o` always reads zero.
- R10: If an event and a status write that clears bit 1 fall on the same edge, bit 1 ends set, and the other bits of the written byte are cleared.
- R11: If an event and a bitmap write fall on the same edge, the bitmaps take the event's result and the written word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpe_wr_i | input | 1 | Byte write strobe for the event registers |
| gpe_addr_i | input | 2 | Byte address in the event register window |
| gpe_wdata_i | input | 8 | Byte write data |
| gpe_rdata_o | output | 8 | Byte read data |
| hp_wr_i | input | 1 | Bitmap write strobe |
| hp_sel_i | input | 1 | Bitmap select: 0 inserted, 1 removed |
| hp_wdata_i | input | 32 | Bitmap write data |
| hp_rdata_o | output | 32 | Selected bitmap |
| ej_wr_i | input | 1 | Eject write strobe |
| ej_wdata_i | input | 32 | Eject slot mask |
| ej_rdata_o | output | 32 | Eject read data, always zero |
| ev_valid_i | input | 1 | Hardware slot event strobe |
| ev_insert_i | input | 1 | 1 for insert, 0 for removal |
| ev_slot_i | input | 5 | Slot number of the event |
| sci_o | output | 1 | One-cycle interrupt pulse |
| ej_valid_o | output | 1 | Eject request strobe |
| ej_slot_o | output | 5 | Slot to eject |

## Verification
A hardware event can land on the same edge as a software access that touches the same state. There are two such collisions: a write that clears status bit 1, and a bitmap write. The bench provokes each collision by driving the event strobe and the software write in the same cycle. It then judges the result at the ports. Status bit 1 must read set while the other cleared bits stay cleared, and the bitmaps must show only the event's slot, with no trace of the written word.

// File: rtl/gpe_hp_pkg.sv
package gpe_hp_pkg;
  localparam int GPE_W      = 16;
  localparam int GPE_BYTES  = GPE_W / 8;
  localparam int HP_GPE_BIT = 1;   // status/enable bit owned by hot-plug

  typedef enum logic [1:0] {
    GPE_STS_LO = 2'd0,
    GPE_STS_HI = 2'd1,
    GPE_EN_LO  = 2'd2,
    GPE_EN_HI  = 2'd3
  } gpe_off_e;
endpackage

// File: rtl/gpe_byte_regs.sv
module gpe_byte_regs
  import gpe_hp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             hp_set_i,
  output logic [7:0]       rdata_o,
  output logic [GPE_W-1:0] en_o
);
  logic [GPE_W-1:0] sts_q, sts_d;
  logic [GPE_W-1:0] en_q, en_d;
  logic             sel_en;
  logic [0:0]       byte_idx;

  assign sel_en   = addr_i[1];
  assign byte_idx = addr_i[0];

  always_comb begin
    sts_d = sts_q;
    en_d  = en_q;
    if (wr_i) begin
      for (int b = 0; b < GPE_BYTES; b++) begin
        if (byte_idx == b[0]) begin
          if (sel_en) en_d[b*8 +: 8] = wdata_i;
          else        sts_d[b*8 +: 8] = sts_q[b*8 +: 8] & ~wdata_i;
        end
      end
    end
    // hardware set wins over a same-cycle software clear
    if (hp_set_i) sts_d[HP_GPE_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q <= '0;
      en_q  <= '0;
    end else begin
      sts_q <= sts_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    unique case (gpe_off_e'(addr_i))
      GPE_STS_LO: rdata_o = sts_q[7:0];
      GPE_STS_HI: rdata_o = sts_q[15:8];
      GPE_EN_LO:  rdata_o = en_q[7:0];
      default:    rdata_o = en_q[15:8];
    endcase
  end

  assign en_o = en_q;

  AST_HP_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hp_set_i |=> sts_q[HP_GPE_BIT]) else $error("hp set lost"); // R10

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_q)) else $error("enable changed without write"); // R4
endmodule

// File: rtl/hp_slot_maps.sv
module hp_slot_maps #(
  parameter int SLOTS  = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [SLOTS-1:0]  wdata_i,
  input  logic              ev_i,
  input  logic              ev_insert_i,
  input  logic [SLOT_W-1:0] ev_slot_i,
  output logic [SLOTS-1:0]  rdata_o
);
  logic [SLOTS-1:0] ins_q, rem_q;
  logic [SLOTS-1:0] slot_mask;

  always_comb begin
    slot_mask = '0;
    slot_mask[ev_slot_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ins_q <= '0;
      rem_q <= '0;
    end else if (ev_i) begin
      ins_q <= ev_insert_i ? slot_mask : '0;
      rem_q <= ev_insert_i ? '0 : slot_mask;
    end else if (wr_i) begin
      if (sel_i) rem_q <= wdata_i;
      else       ins_q <= wdata_i;
    end
  end

  assign rdata_o = sel_i ? rem_q : ins_q;

  AST_ONE_SLOT_AFTER_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> ($countones({ins_q, rem_q}) == 1)) else $error("event map"); // R6

  AST_MAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ev_i && !wr_i) |=> ($stable(ins_q) && $stable(rem_q))) else $error("map drift"); // R5
endmodule

// File: rtl/eject_lsb_enc.sv
module eject_lsb_enc #(
  parameter int SLOTS  = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SLOTS-1:0]  wdata_i,
  output logic              valid_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [SLOT_W-1:0] lsb_idx;
  logic              any_set;

  assign any_set = |wdata_i;

  always_comb begin
    lsb_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (wdata_i[i]) lsb_idx = i[SLOT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      slot_o  <= '0;
    end else begin
      valid_o <= wr_i && any_set;
      if (wr_i && any_set) slot_o <= lsb_idx;
    end
  end

  AST_EJECT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i == '0) |=> !valid_o) else $error("eject on zero"); // R8

  AST_EJECT_BIT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i != '0) |=> valid_o) else $error("eject missed"); // R8
endmodule

// File: rtl/gpe_hotplug_unit.sv
module gpe_hotplug_unit
  import gpe_hp_pkg::*;
#(
  parameter int SLOTS  = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gpe_wr_i,
  input  logic [1:0]        gpe_addr_i,
  input  logic [7:0]        gpe_wdata_i,
  output logic [7:0]        gpe_rdata_o,
  input  logic              hp_wr_i,
  input  logic              hp_sel_i,
  input  logic [SLOTS-1:0]  hp_wdata_i,
  output logic [SLOTS-1:0]  hp_rdata_o,
  input  logic              ej_wr_i,
  input  logic [SLOTS-1:0]  ej_wdata_i,
  output logic [SLOTS-1:0]  ej_rdata_o,
  input  logic              ev_valid_i,
  input  logic              ev_insert_i,
  input  logic [SLOT_W-1:0] ev_slot_i,
  output logic              sci_o,
  output logic              ej_valid_o,
  output logic [SLOT_W-1:0] ej_slot_o
);
  logic [GPE_W-1:0] gpe_en;
  logic             sci_q;

  gpe_byte_regs u_gpe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (gpe_wr_i),
    .addr_i   (gpe_addr_i),
    .wdata_i  (gpe_wdata_i),
    .hp_set_i (ev_valid_i),
    .rdata_o  (gpe_rdata_o),
    .en_o     (gpe_en)
  );

  hp_slot_maps #(.SLOTS(SLOTS)) u_maps (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (hp_wr_i),
    .sel_i       (hp_sel_i),
    .wdata_i     (hp_wdata_i),
    .ev_i        (ev_valid_i),
    .ev_insert_i (ev_insert_i),
    .ev_slot_i   (ev_slot_i),
    .rdata_o     (hp_rdata_o)
  );

  eject_lsb_enc #(.SLOTS(SLOTS)) u_eject (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (ej_wr_i),
    .wdata_i (ej_wdata_i),
    .valid_o (ej_valid_o),
    .slot_o  (ej_slot_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sci_q <= 1'b0;
    else         sci_q <= ev_valid_i && gpe_en[HP_GPE_BIT];
  end

  assign sci_o      = sci_q;
  assign ej_rdata_o = '0;

  AST_SCI_FROM_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sci_o |-> $past(ev_valid_i)) else $error("sci without event"); // R7

  AST_SCI_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gpe_en[HP_GPE_BIT] |=> !sci_o) else $error("sci while masked"); // R7
endmodule

// File: tb/gpe_hotplug_unit_bench.sv
`timescale 1ns/1ps
module gpe_hotplug_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gpe_wr = 1'b0;
  logic [1:0]  gpe_addr = '0;
  logic [7:0]  gpe_wdata = '0;
  logic [7:0]  gpe_rdata;
  logic        hp_wr = 1'b0;
  logic        hp_sel = 1'b0;
  logic [31:0] hp_wdata = '0;
  logic [31:0] hp_rdata;
  logic        ej_wr = 1'b0;
  logic [31:0] ej_wdata = '0;
  logic [31:0] ej_rdata;
  logic        ev_valid = 1'b0;
  logic        ev_insert = 1'b0;
  logic [4:0]  ev_slot = '0;
  logic        sci;
  logic        ej_valid;
  logic [4:0]  ej_slot;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpe_hotplug_unit u_gpe_hotplug_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .gpe_wr_i(gpe_wr), .gpe_addr_i(gpe_addr), .gpe_wdata_i(gpe_wdata), .gpe_rdata_o(gpe_rdata),
    .hp_wr_i(hp_wr), .hp_sel_i(hp_sel), .hp_wdata_i(hp_wdata), .hp_rdata_o(hp_rdata),
    .ej_wr_i(ej_wr), .ej_wdata_i(ej_wdata), .ej_rdata_o(ej_rdata),
    .ev_valid_i(ev_valid), .ev_insert_i(ev_insert), .ev_slot_i(ev_slot),
    .sci_o(sci), .ej_valid_o(ej_valid), .ej_slot_o(ej_slot)
  );

  // op: 0 gpe write, 1 gpe read, 2 map write, 3 map read, 4 event (a[0]=insert, exp=sci), 5 eject (exp={valid,slot})
  localparam int N = 39;
  localparam logic [72:0] VECS [N] = '{
    {4'd1, 3'd1, 2'd0, 32'h0, 32'h0},               // R1
    {4'd1, 3'd1, 2'd1, 32'h0, 32'h0},
    {4'd1, 3'd1, 2'd2, 32'h0, 32'h0},
    {4'd1, 3'd1, 2'd3, 32'h0, 32'h0},
    {4'd1, 3'd3, 2'd0, 32'h0, 32'h0},
    {4'd1, 3'd3, 2'd1, 32'h0, 32'h0},
    {4'd4, 3'd0, 2'd2, 32'hA5, 32'h0},              // R4
    {4'd4, 3'd0, 2'd3, 32'h3C, 32'h0},
    {4'd2, 3'd1, 2'd2, 32'h0, 32'hA5},              // R2
    {4'd2, 3'd1, 2'd3, 32'h0, 32'h3C},
    {4'd4, 3'd0, 2'd2, 32'h5A, 32'h0},
    {4'd4, 3'd1, 2'd2, 32'h0, 32'h5A},
    {4'd4, 3'd1, 2'd3, 32'h0, 32'h3C},
    {4'd7, 3'd4, 2'd1, 32'd5, 32'h1},               // R7 enabled
    {4'd6, 3'd3, 2'd0, 32'h0, 32'h20},              // R6
    {4'd6, 3'd3, 2'd1, 32'h0, 32'h0},
    {4'd6, 3'd1, 2'd0, 32'h0, 32'h02},
    {4'd2, 3'd1, 2'd1, 32'h0, 32'h0},
    {4'd5, 3'd2, 2'd1, 32'hDEADBEEF, 32'h0},        // R5
    {4'd5, 3'd3, 2'd1, 32'h0, 32'hDEADBEEF},
    {4'd5, 3'd2, 2'd0, 32'h12345678, 32'h0},
    {4'd5, 3'd3, 2'd0, 32'h0, 32'h12345678},
    {4'd6, 3'd4, 2'd0, 32'd31, 32'h1},              // removal slot 31
    {4'd6, 3'd3, 2'd0, 32'h0, 32'h0},
    {4'd6, 3'd3, 2'd1, 32'h0, 32'h80000000},
    {4'd3, 3'd0, 2'd0, 32'hFD, 32'h0},              // R3
    {4'd3, 3'd1, 2'd0, 32'h0, 32'h02},
    {4'd3, 3'd0, 2'd1, 32'hFF, 32'h0},
    {4'd3, 3'd1, 2'd0, 32'h0, 32'h02},
    {4'd3, 3'd0, 2'd0, 32'h02, 32'h0},
    {4'd3, 3'd1, 2'd0, 32'h0, 32'h0},
    {4'd4, 3'd0, 2'd2, 32'h00, 32'h0},
    {4'd7, 3'd4, 2'd1, 32'd0, 32'h0},               // R7 masked
    {4'd6, 3'd1, 2'd0, 32'h0, 32'h02},
    {4'd6, 3'd3, 2'd0, 32'h0, 32'h1},
    {4'd8, 3'd5, 2'd0, 32'h0, 32'h0},               // R8 zero
    {4'd8, 3'd5, 2'd0, 32'h50, 32'h24},
    {4'd8, 3'd5, 2'd0, 32'h80000000, 32'h3F},
    {4'd8, 3'd5, 2'd0, 32'hFFFFFFFF, 32'h20}
  };

  task automatic check(input int req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got=%h exp=%h", req, what, got, exp);
    end
  endtask

  task automatic run_vec(input logic [72:0] v);
    logic [3:0]  req;
    logic [2:0]  op;
    logic [1:0]  a;
    logic [31:0] d, e;
    {req, op, a, d, e} = v;
    @(negedge clk);
    case (op)
      3'd0: begin gpe_wr = 1; gpe_addr = a; gpe_wdata = d[7:0]; @(negedge clk); gpe_wr = 0; end
      3'd1: begin gpe_addr = a; #1 check(req, "gpe read", {24'h0, gpe_rdata}, e); end
      3'd2: begin hp_wr = 1; hp_sel = a[0]; hp_wdata = d; @(negedge clk); hp_wr = 0; end
      3'd3: begin hp_sel = a[0]; #1 check(req, "map read", hp_rdata, e); end
      3'd4: begin
        ev_valid = 1; ev_insert = a[0]; ev_slot = d[4:0];
        @(negedge clk); ev_valid = 0;
        check(req, "sci pulse", {31'h0, sci}, e);
        @(negedge clk);
        check(7, "sci width", {31'h0, sci}, 32'h0);   // R7
      end
      default: begin
        ej_wr = 1; ej_wdata = d;
        @(negedge clk); ej_wr = 0;
        check(req, "eject strobe", {26'h0, ej_valid, ej_slot & {5{ej_valid}}}, e);
        @(negedge clk);
        check(8, "eject width", {31'h0, ej_valid}, 32'h0); // R8
      end
    endcase
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, "reset sci", {31'h0, sci}, 32'h0);            // R1
    check(1, "reset eject", {31'h0, ej_valid}, 32'h0);     // R1
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) run_vec(VECS[i]);

    // R9: eject read stays zero
    @(negedge clk); ej_wr = 1; ej_wdata = 32'h0000_0100;
    #1 check(9, "eject read", ej_rdata, 32'h0);
    @(negedge clk); ej_wr = 0;
    check(9, "eject read after", ej_rdata, 32'h0);

    // R10: event and clear of bit 1 on the same edge
    gpe_wr = 1; gpe_addr = 2'd0; gpe_wdata = 8'hFF;
    @(negedge clk); gpe_wr = 0;
    gpe_addr = 2'd0; #1 check(10, "status pre-cleared", {24'h0, gpe_rdata}, 32'h0);
    @(negedge clk);
    gpe_wr = 1; gpe_addr = 2'd0; gpe_wdata = 8'hFF;
    ev_valid = 1; ev_insert = 1; ev_slot = 5'd3;
    @(negedge clk); gpe_wr = 0; ev_valid = 0;
    gpe_addr = 2'd0; #1 check(10, "set beats clear", {24'h0, gpe_rdata}, 32'h02);

    // R11: event and bitmap writes on the same edge
    @(negedge clk);
    hp_wr = 1; hp_sel = 1'b0; hp_wdata = 32'hFFFF_FFFF;
    ev_valid = 1; ev_insert = 1; ev_slot = 5'd7;
    @(negedge clk); hp_wr = 0; ev_valid = 0;
    hp_sel = 1'b0; #1 check(11, "inserted after collision", hp_rdata, 32'h80);
    @(negedge clk);
    hp_wr = 1; hp_sel = 1'b1; hp_wdata = 32'hAAAA_5555;
    ev_valid = 1; ev_insert = 0; ev_slot = 5'd2;
    @(negedge clk); hp_wr = 0; ev_valid = 0;
    hp_sel = 1'b1; #1 check(11, "removed after collision", hp_rdata, 32'h4);
    hp_sel = 1'b0; #1 check(11, "inserted wiped", hp_rdata, 32'h0);

    // R1: reset mid-run clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    gpe_addr = 2'd0; #1 check(1, "status after reset", {24'h0, gpe_rdata}, 32'h0);
    hp_sel = 1'b1; #1 check(1, "removed after reset", hp_rdata, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule